// File: doc/BRIEF.md
# Tag-only cache hit/miss classifier

This block models the tag side of a set-associative cache without holding any data. A producer hands it one memory request at a time: a 32-bit byte address and a flag that says whether the request reads or writes. The block looks the address up in its tag store. It reports hit or miss and updates its valid, dirty and replacement state. It also charges the request a cycle cost. That cost models one cycle of cache access plus 100 cycles for every 4-byte word moved to or from memory.

The geometry is fixed at build time through parameters: the number of sets, the ways per set and the bytes per block, each a power of two. The smallest legal geometry is one set, one way and 4-byte blocks. Three static inputs select the policies:

- whether a write miss allocates a line;
- whether writes go straight through to memory or stay in the cache as dirty lines;
- whether the oldest-used way or the earliest-filled way is evicted.

Running totals are kept for reads, writes, their hits and misses, and the accumulated cycle cost. Those totals let a trace replay measure a cache configuration.

Top module: `tagcache_core`

## Requirements
- R1: After a synchronous reset every counter reads zero, `req_ready` is 1 under a legal configuration, and the first access to any address is a miss.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the following cycle. `resp_valid` is 1 for exactly one cycle, one cycle after acceptance, and the counters already hold the new totals in that cycle.
- R3: Address bits [log2(block bytes)-1:0] are ignored, the next log2(sets) bits pick the set, and the remaining upper bits form the tag. Two addresses in the same block hit on each other, and blocks in different sets do not displace each other.
- R4: A read hit costs 1 cycle. A read miss costs 100 × (block bytes / 4) + 1 cycles, plus the write-back cost of R9 when applicable.
- R5: A write hit costs 101 cycles when write-through is selected. In write-back mode it costs 1 cycle and marks the line dirty.
- R6: With allocation on, a write miss fills the line. It costs 100 × (block bytes / 4) + 1 cycles, plus 100 under write-through and plus the R9 cost when applicable. Under write-back the filled line is dirty.
- R7: With allocation off, a write miss costs 100 cycles and leaves the tag store unchanged, so a following read of the same block misses.
- R8: When allocation is off and write-back is selected, `cfg_err` is 1 and `req_ready` stays 0. Requests offered in that state produce no response and change no counter.
- R9: Evicting a dirty line adds 100 × (block bytes / 4) cycles to the miss that evicts it.
- R10: A fill always uses an invalid way of the set, when one exists, before evicting a valid way.
- R11: With `cfg_lru` = 1, a fill into a full set replaces the way that has gone longest without a hit or fill.
- R12: With `cfg_lru` = 0, a fill into a full set replaces the way that was filled earliest, and hits do not change that choice.
- R13: The read, write, read-hit, read-miss, write-hit and write-miss counters each advance by one only for their own kind of request, so reads equal read hits plus read misses and writes equal write hits plus write misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_alloc | input | 1 | 1: a write miss allocates the line |
| cfg_wthru | input | 1 | 1: write-through, 0: write-back |
| cfg_lru | input | 1 | 1: least-recently-used victim, 0: first-in victim |
| cfg_err | output | 1 | Illegal policy combination, requests refused |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Byte address of the request |
| req_store | input | 1 | 1: write, 0: read |
| resp_valid | output | 1 | One-cycle pulse: request resolved |
| resp_hit | output | 1 | Result of the resolved request |
| cnt_loads | output | CNT_W | Reads accepted |
| cnt_stores | output | CNT_W | Writes accepted |
| cnt_ld_hit | output | CNT_W | Read hits |
| cnt_ld_miss | output | CNT_W | Read misses |
| cnt_st_hit | output | CNT_W | Write hits |
| cnt_st_miss | output | CNT_W | Write misses |
| cnt_cycles | output | CYC_W | Accumulated modelled cycles |

## Verification
A corrupted valid bit or tag shows up at the ports as a wrong `resp_hit` on the very next access to that block. A stale dirty bit stays hidden until its line is evicted, then surfaces as a cycle total off by exactly one block transfer. A broken age or first-in pointer shows nothing until a set fills, and then a later access to the wrongly evicted block misses where a hit is due. The bench therefore drives each set past full and re-reads the survivors, and compares every counter on every response.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int unsigned MEM_WORD_CYC = 100;
  localparam int unsigned WORD_BYTES   = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOOK = 1'b1
  } tc_state_e;

  // Modelled cycle cost of one resolved request.
  function automatic logic [31:0] access_cost(
    input logic        is_store,
    input logic        hit,
    input logic        alloc,
    input logic        wthru,
    input logic        wb_dirty,
    input logic [31:0] words
  );
    logic [31:0] blk_xfer;
    logic [31:0] c;
    blk_xfer = words * MEM_WORD_CYC;
    if (is_store && !hit && !alloc) begin
      c = MEM_WORD_CYC;
    end else begin
      c = 32'd1;
      if (!hit) c = c + blk_xfer + (wb_dirty ? blk_xfer : 32'd0);
      if (is_store && wthru) c = c + MEM_WORD_CYC;
    end
    return c;
  endfunction

endpackage

// File: rtl/tc_addr_split.sv
module tc_addr_split #(
  parameter int unsigned SETS      = 16,
  parameter int unsigned BLK_BYTES = 16,
  localparam int unsigned OFF_W  = $clog2(BLK_BYTES),
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned IDX_WS = (IDX_W > 0) ? IDX_W : 1,
  localparam int unsigned TAG_W  = 32 - OFF_W - IDX_W
) (
  input  logic [31:0]       addr,
  output logic [IDX_WS-1:0] set_idx,
  output logic [TAG_W-1:0]  tag
);
  logic unused_offset;
  assign unused_offset = ^addr[OFF_W-1:0];

  assign tag = addr[31 -: TAG_W];

  generate
    if (IDX_W > 0) begin : g_idx
      assign set_idx = addr[OFF_W +: IDX_WS];
    end else begin : g_one_set
      assign set_idx = '0;
    end
  endgenerate
endmodule

// File: rtl/tc_way_match.sv
module tc_way_match #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned WAY_WS = 2
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [TAG_W-1:0]            look_tag,
  output logic [WAYS-1:0]             match_vec,
  output logic                        hit,
  output logic [WAY_WS-1:0]           hit_way
);
  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_cmp
      assign match_vec[w] = way_valid[w] && (way_tag[w] == look_tag);
    end
  endgenerate

  assign hit = |match_vec;

  always_comb begin
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_way = WAY_WS'(i);
    end
  end
endmodule

// File: rtl/tc_victim_pick.sv
module tc_victim_pick #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned WAY_WS = 2
) (
  input  logic [WAYS-1:0]              way_valid,
  input  logic [WAYS-1:0][WAY_WS-1:0]  way_age,
  input  logic [WAY_WS-1:0]            fifo_ptr,
  input  logic                         use_lru,
  output logic [WAY_WS-1:0]            victim_way,
  output logic                         victim_free
);
  logic [WAY_WS-1:0] free_way;
  logic [WAY_WS-1:0] oldest_way;

  always_comb begin
    free_way    = '0;
    victim_free = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) begin
        free_way    = WAY_WS'(i);
        victim_free = 1'b1;
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (way_age[i] == WAY_WS'(WAYS - 1)) oldest_way = WAY_WS'(i);
    end
  end

  always_comb begin
    if (victim_free)  victim_way = free_way;
    else if (use_lru) victim_way = oldest_way;
    else              victim_way = fifo_ptr;
  end
endmodule

// File: rtl/tagcache_core.sv
module tagcache_core #(
  parameter int unsigned SETS      = 16,
  parameter int unsigned WAYS      = 4,
  parameter int unsigned BLK_BYTES = 16,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned CYC_W     = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_alloc,
  input  logic             cfg_wthru,
  input  logic             cfg_lru,
  output logic             cfg_err,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic             req_store,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [CNT_W-1:0] cnt_loads,
  output logic [CNT_W-1:0] cnt_stores,
  output logic [CNT_W-1:0] cnt_ld_hit,
  output logic [CNT_W-1:0] cnt_ld_miss,
  output logic [CNT_W-1:0] cnt_st_hit,
  output logic [CNT_W-1:0] cnt_st_miss,
  output logic [CYC_W-1:0] cnt_cycles
);
  import tc_pkg::*;

  localparam int unsigned OFF_W  = $clog2(BLK_BYTES);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned IDX_WS = (IDX_W > 0) ? IDX_W : 1;
  localparam int unsigned TAG_W  = 32 - OFF_W - IDX_W;
  localparam int unsigned WAY_WS = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned WORDS  = BLK_BYTES / WORD_BYTES;

  // tag store and policy state
  logic [WAYS-1:0]              valid_q [SETS];
  logic [WAYS-1:0]              dirty_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
  logic [WAYS-1:0][WAY_WS-1:0]  age_q   [SETS];
  logic [WAY_WS-1:0]            fifo_q  [SETS];

  tc_state_e   state_q;
  logic [31:0] r_addr_q;
  logic        r_store_q;

  // lookup view of the addressed set
  logic [IDX_WS-1:0]           set_idx;
  logic [TAG_W-1:0]            look_tag;
  logic [WAYS-1:0]             cur_valid;
  logic [WAYS-1:0]             cur_dirty;
  logic [WAYS-1:0][TAG_W-1:0]  cur_tag;
  logic [WAYS-1:0][WAY_WS-1:0] cur_age;
  logic [WAYS-1:0][WAY_WS-1:0] age_nxt;
  logic [WAYS-1:0]             match_vec;
  logic                        hit;
  logic [WAY_WS-1:0]           hit_way;
  logic [WAY_WS-1:0]           victim_way;
  logic                        victim_free;
  logic [WAY_WS-1:0]           touch_way;
  logic [31:0]                 cost;

  // named events for the checker
  logic ev_accept, ev_done, ev_hit, ev_fill, ev_wb;

  tc_addr_split #(.SETS(SETS), .BLK_BYTES(BLK_BYTES)) u_split (
    .addr    (r_addr_q),
    .set_idx (set_idx),
    .tag     (look_tag)
  );

  assign cur_valid = valid_q[set_idx];
  assign cur_dirty = dirty_q[set_idx];
  assign cur_tag   = tag_q[set_idx];
  assign cur_age   = age_q[set_idx];

  tc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_WS(WAY_WS)) u_match (
    .way_valid (cur_valid),
    .way_tag   (cur_tag),
    .look_tag  (look_tag),
    .match_vec (match_vec),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  tc_victim_pick #(.WAYS(WAYS), .WAY_WS(WAY_WS)) u_victim (
    .way_valid   (cur_valid),
    .way_age     (cur_age),
    .fifo_ptr    (fifo_q[set_idx]),
    .use_lru     (cfg_lru),
    .victim_way  (victim_way),
    .victim_free (victim_free)
  );

  assign cfg_err   = !cfg_alloc && !cfg_wthru;
  assign req_ready = (state_q == ST_IDLE) && !cfg_err;
  assign ev_accept = req_valid && req_ready;
  assign ev_done   = (state_q == ST_LOOK);
  assign ev_hit    = ev_done && hit;
  assign ev_fill   = ev_done && !hit && (!r_store_q || cfg_alloc);
  assign ev_wb     = ev_fill && !victim_free && cur_dirty[victim_way];
  assign touch_way = hit ? hit_way : victim_way;
  assign cost      = access_cost(r_store_q, hit, cfg_alloc, cfg_wthru, ev_wb, WORDS);

  // age 0 is most recent; ages form a permutation per set
  always_comb begin
    age_nxt = cur_age;
    for (int v = 0; v < WAYS; v++) begin
      if (WAY_WS'(v) == touch_way)
        age_nxt[v] = '0;
      else if (cur_age[v] < cur_age[touch_way])
        age_nxt[v] = cur_age[v] + WAY_WS'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      r_addr_q   <= '0;
      r_store_q  <= 1'b0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
    end else begin
      resp_valid <= ev_done;
      if (ev_done) resp_hit <= hit;
      if (ev_accept) begin
        r_addr_q  <= req_addr;
        r_store_q <= req_store;
        state_q   <= ST_LOOK;
      end else if (ev_done) begin
        state_q   <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        fifo_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_WS'(w);
      end
    end else begin
      if (ev_hit) begin
        age_q[set_idx] <= age_nxt;
        if (r_store_q && !cfg_wthru) dirty_q[set_idx][hit_way] <= 1'b1;
      end
      if (ev_fill) begin
        age_q[set_idx]               <= age_nxt;
        valid_q[set_idx][victim_way] <= 1'b1;
        tag_q[set_idx][victim_way]   <= look_tag;
        dirty_q[set_idx][victim_way] <= r_store_q && !cfg_wthru;
        fifo_q[set_idx] <= (fifo_q[set_idx] == WAY_WS'(WAYS - 1)) ?
                           '0 : fifo_q[set_idx] + WAY_WS'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_loads   <= '0;
      cnt_stores  <= '0;
      cnt_ld_hit  <= '0;
      cnt_ld_miss <= '0;
      cnt_st_hit  <= '0;
      cnt_st_miss <= '0;
      cnt_cycles  <= '0;
    end else if (ev_done) begin
      cnt_cycles <= cnt_cycles + CYC_W'(cost);
      if (r_store_q) begin
        cnt_stores <= cnt_stores + CNT_W'(1);
        if (hit) cnt_st_hit  <= cnt_st_hit + CNT_W'(1);
        else     cnt_st_miss <= cnt_st_miss + CNT_W'(1);
      end else begin
        cnt_loads <= cnt_loads + CNT_W'(1);
        if (hit) cnt_ld_hit  <= cnt_ld_hit + CNT_W'(1);
        else     cnt_ld_miss <= cnt_ld_miss + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned CYC_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_err,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             ev_accept,
  input logic             ev_done,
  input logic [WAYS-1:0]  match_vec,
  input logic [CNT_W-1:0] cnt_loads,
  input logic [CNT_W-1:0] cnt_stores,
  input logic [CNT_W-1:0] cnt_ld_hit,
  input logic [CNT_W-1:0] cnt_ld_miss,
  input logic [CNT_W-1:0] cnt_st_hit,
  input logic [CNT_W-1:0] cnt_st_miss,
  input logic [CYC_W-1:0] cnt_cycles
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_loads == '0 && cnt_stores == '0 && cnt_cycles == '0)); // R1

  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> (resp_valid == 1'b0 && req_ready == 1'b0)); // R2

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    ev_done |-> !req_ready); // R2

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec)); // R3

  AST_CYC_GROWS: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (cnt_cycles > $past(cnt_cycles))); // R4

  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !req_ready); // R8

  AST_LOAD_SPLIT: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (cnt_loads == cnt_ld_hit + cnt_ld_miss)); // R13

  AST_STORE_SPLIT: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (cnt_stores == cnt_st_hit + cnt_st_miss)); // R13

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ev_done |=> ($stable(cnt_cycles) && $stable(cnt_loads) && $stable(cnt_stores))); // R13
endmodule

bind tagcache_core tc_checker #(.WAYS(WAYS), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_err     (cfg_err),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .ev_accept   (ev_accept),
  .ev_done     (ev_done),
  .match_vec   (match_vec),
  .cnt_loads   (cnt_loads),
  .cnt_stores  (cnt_stores),
  .cnt_ld_hit  (cnt_ld_hit),
  .cnt_ld_miss (cnt_ld_miss),
  .cnt_st_hit  (cnt_st_hit),
  .cnt_st_miss (cnt_st_miss),
  .cnt_cycles  (cnt_cycles)
);

// File: tb/tb_tagcache_core.sv
module tb_tagcache_core;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 4;
  localparam int NWAYS = 2;
  localparam int BLK   = 16;
  localparam int XFER  = 100 * (BLK / 4);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_alloc = 1'b1, cfg_wthru = 1'b0, cfg_lru = 1'b1;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_store = 1'b0;
  logic        resp_valid, resp_hit;
  logic [31:0] cnt_loads, cnt_stores, cnt_ld_hit, cnt_ld_miss, cnt_st_hit, cnt_st_miss;
  logic [47:0] cnt_cycles;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tagcache_core #(.SETS(NSETS), .WAYS(NWAYS), .BLK_BYTES(BLK)) dut (
    .clk(clk), .rst(rst), .cfg_alloc(cfg_alloc), .cfg_wthru(cfg_wthru),
    .cfg_lru(cfg_lru), .cfg_err(cfg_err), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_store(req_store),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .cnt_loads(cnt_loads),
    .cnt_stores(cnt_stores), .cnt_ld_hit(cnt_ld_hit), .cnt_ld_miss(cnt_ld_miss),
    .cnt_st_hit(cnt_st_hit), .cnt_st_miss(cnt_st_miss), .cnt_cycles(cnt_cycles)
  );

  typedef struct {
    bit     hit;
    longint ld, st, lh, lm, sh, sm, cyc;
    string  req;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;

  // reference model state
  bit          m_valid [NSETS][NWAYS];
  bit          m_dirty [NSETS][NWAYS];
  int unsigned m_tag   [NSETS][NWAYS];
  int          m_used  [NSETS][NWAYS];
  int          m_born  [NSETS][NWAYS];
  int          tick;
  longint e_ld, e_st, e_lh, e_lm, e_sh, e_sm, e_cyc;

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (resp_valid) begin
      if (q.size() == 0) begin
        chk("R2", 1, 0, "response without request");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, longint'(resp_hit), longint'(e.hit), "hit");
        chk(e.req, longint'(cnt_cycles), e.cyc, "cycles");
        chk("R13", longint'(cnt_loads), e.ld, "loads");
        chk("R13", longint'(cnt_stores), e.st, "stores");
        chk("R13", longint'(cnt_ld_hit), e.lh, "load hits");
        chk("R13", longint'(cnt_ld_miss), e.lm, "load misses");
        chk("R13", longint'(cnt_st_hit), e.sh, "store hits");
        chk("R13", longint'(cnt_st_miss), e.sm, "store misses");
      end
    end
  end

  task automatic do_reset(input bit alloc, input bit wt, input bit lru);
    @(negedge clk);
    rst = 1'b1;
    cfg_alloc = alloc; cfg_wthru = wt; cfg_lru = lru;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin
        m_valid[s][w] = 0; m_dirty[s][w] = 0; m_used[s][w] = 0; m_born[s][w] = 0;
      end
    tick = 1;
    e_ld = 0; e_st = 0; e_lh = 0; e_lm = 0; e_sh = 0; e_sm = 0; e_cyc = 0;
    @(negedge clk);
    chk("R1", longint'(cnt_loads) + longint'(cnt_stores), 0, "access counters after reset");
    chk("R1", longint'(cnt_cycles), 0, "cycles after reset");
  endtask

  // driver: model the access, push the expectation, drive the handshake
  task automatic access(input logic [31:0] a, input bit st, input string req);
    exp_t e;
    int s, hw, vw, cost;
    int unsigned t;
    bit hit;
    s = int'((a >> 4) % NSETS);
    t = a >> 6;
    hit = 0; hw = 0;
    for (int w = 0; w < NWAYS; w++)
      if (m_valid[s][w] && m_tag[s][w] == t) begin hit = 1; hw = w; end
    if (hit) begin
      cost = 1 + ((st && cfg_wthru) ? 100 : 0);
      m_used[s][hw] = tick;
      if (st && !cfg_wthru) m_dirty[s][hw] = 1;
    end else if (st && !cfg_alloc) begin
      cost = 100;
    end else begin
      vw = -1;
      for (int w = 0; w < NWAYS; w++) if (!m_valid[s][w] && vw < 0) vw = w;
      if (vw < 0) begin
        vw = 0;
        for (int w = 1; w < NWAYS; w++)
          if (cfg_lru ? (m_used[s][w] < m_used[s][vw]) : (m_born[s][w] < m_born[s][vw])) vw = w;
      end
      cost = XFER + 1 + ((m_valid[s][vw] && m_dirty[s][vw]) ? XFER : 0)
                      + ((st && cfg_wthru) ? 100 : 0);
      m_valid[s][vw] = 1; m_tag[s][vw] = t; m_dirty[s][vw] = st && !cfg_wthru;
      m_used[s][vw] = tick; m_born[s][vw] = tick;
    end
    tick++;
    if (st) begin e_st++; if (hit) e_sh++; else e_sm++; end
    else    begin e_ld++; if (hit) e_lh++; else e_lm++; end
    e_cyc += cost;
    e.hit = hit; e.ld = e_ld; e.st = e_st; e.lh = e_lh; e.lm = e_lm;
    e.sh = e_sh; e.sm = e_sm; e.cyc = e_cyc; e.req = req;
    q.push_back(e);

    @(negedge clk);
    chk("R2", longint'(req_ready), 1, "ready before request");
    req_addr = a; req_store = st; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", longint'(req_ready), 0, "ready while resolving");
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] adr(input int tg, input int st, input int off);
    return 32'((tg << 6) | (st << 4) | off);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    chk("R2", 0, 1, "watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // write-back, allocate, LRU
    do_reset(1, 0, 1);
    chk("R1", longint'(cfg_err), 0, "no config error");
    access(adr(1, 0, 0), 0, "R1");   // cold miss
    access(adr(1, 0, 8), 0, "R3");   // same block, other offset
    access(adr(1, 0, 4), 1, "R5");   // write-back hit, dirty
    access(adr(2, 0, 0), 0, "R10");  // fills the free way
    access(adr(1, 0, 0), 0, "R4");   // hit, tag 1 most recent
    access(adr(3, 0, 0), 0, "R11");  // evicts tag 2
    access(adr(2, 0, 0), 0, "R9");   // evicts dirty tag 1
    access(adr(1, 1, 0), 0, "R3");   // other set
    access(adr(3, 0, 0), 0, "R11");  // survivor still present
    access(adr(4, 2, 0), 1, "R6");   // allocating write miss
    access(adr(4, 2, 12), 1, "R5");
    // write-through, allocate, first-in
    do_reset(1, 1, 0);
    access(adr(1, 0, 0), 0, "R4");
    access(adr(2, 0, 0), 0, "R10");
    access(adr(1, 0, 0), 0, "R12");  // hit must not protect tag 1
    access(adr(3, 0, 0), 1, "R6");   // evicts tag 1 (earliest)
    access(adr(1, 0, 0), 0, "R12");  // evicts tag 2
    access(adr(2, 0, 0), 0, "R12");
    access(adr(2, 0, 4), 1, "R5");   // write-through hit
    // no allocation, write-through
    do_reset(0, 1, 1);
    access(adr(5, 3, 0), 1, "R7");   // store miss, no fill
    access(adr(5, 3, 0), 0, "R7");   // still a miss
    access(adr(5, 3, 0), 1, "R5");
    // illegal combination
    do_reset(0, 0, 1);
    chk("R8", longint'(cfg_err), 1, "config error flag");
    chk("R8", longint'(req_ready), 0, "ready under bad config");
    req_addr = adr(1, 0, 0); req_store = 1'b0; req_valid = 1'b1;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8", longint'(cnt_loads) + longint'(cnt_stores), 0, "no request counted");
    chk("R8", longint'(cnt_cycles), 0, "no cycles charged");
    chk("R8", longint'(q.size()), 0, "queue drained");
    summary();
    $finish;
  end
endmodule